// File: doc/BRIEF.md
# Keyboard Matrix Input Latch

This block is an input port for a keyboard and joystick matrix. It sits on a shared 8-bit bus that carries one bus cycle per clock phase, and it answers at one 16-bit address. Each capture takes the byte on the data bus as a row selector. A selector bit at 0 enables its row. The block ANDs the active-low key states of all enabled rows and stores the result, so a pressed key in any enabled row pulls its column bit low. A register read returns a value that was stored in an earlier bus cycle, never one sampled during the read itself.

A mode input picks one of two behaviours. In normal mode, capture is inhibited except in a bus cycle that writes the port register, so the stored value changes only on a write. In degraded mode the inhibit is gone. Every valid bus cycle then captures with whatever byte is on the data bus: a CPU access to any address, a read, or an idle video fetch. A read in this mode therefore reflects the bus byte of the previous valid cycle. Software can use this to supply a selector byte by placing it on the bus one cycle before the read.

Top module: `kmx_latch_top`

## Requirements
- R1: While `rst` is high at a clock edge, the stored value, `sel_lines` and `rd_data` become 0xFF and `rd_valid` becomes 0.
- R2: In normal mode, a valid write (`bus_rw`=0) to `PORT_ADDR` stores the AND of every row `r` (0 to ROWS-1) for which bit `r` of the write byte is 0. Bit `c` of row `r` is `row_n[r*8+c]`, and 0 means pressed. `sel_lines` shows the write byte from the next cycle on.
- R3: In normal mode, no other cycle changes the stored value or `sel_lines`: not reads, not writes to other addresses, not cycles with `bus_valid` low, and not changes on `row_n`.
- R4: In degraded mode, every cycle with `bus_valid` high captures under the rule of R2, using that cycle's `bus_data`, whatever the address and direction.
- R5: In degraded mode, a cycle with `bus_valid` low captures nothing.
- R6: A valid read (`bus_rw`=1) of `PORT_ADDR` sets `rd_valid` high for exactly the next cycle. In that cycle `rd_data` holds the value stored before the read cycle, even if the read cycle itself captures.
- R7: The address decode compares all 16 bits. An address that differs in any single bit neither writes nor reads the port.
- R8: A selector byte of 0xFF enables no row and stores 0xFF. A selector byte of 0x00 enables all rows.
- R9: `rd_data` keeps its value in every cycle that follows a cycle without a port read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per bus cycle |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Current bus cycle is valid |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 8 | Byte on the data bus this cycle |
| degraded | input | 1 | 1 = capture inhibit removed |
| row_n | input | ROWS*8 | Active-low key states, row r in bits r*8+7..r*8 |
| sel_lines | output | 8 | Selector byte of the latest capture |
| rd_data | output | 8 | Read data, registered |
| rd_valid | output | 1 | High in the cycle after a port read |

## Verification
In degraded mode, a port read is also a capture cycle, so capture and readback fall in the same bus cycle. The bench provokes this by reading directly after valid cycles that carry chosen selector bytes, and by putting a different byte on the bus during the read itself. It then requires `rd_data` to match the earlier byte's capture and not the concurrent one. In normal mode, back-to-back write and read cycles are judged the same way. A cycle-by-cycle reference model is compared on every clock, through directed phases and a long random mix of modes, addresses and matrix contents.

// File: rtl/kmx_pkg.sv
package kmx_pkg;
  localparam int AW = 16;
  localparam int DW = 8;

  typedef logic [AW-1:0] addr_t;
  typedef logic [DW-1:0] byte_t;

  // decoded per-cycle actions
  typedef struct packed {
    logic wr_hit;
    logic rd_hit;
    logic smp;
  } act_t;
endpackage

// File: rtl/kmx_decode.sv
module kmx_decode
  import kmx_pkg::*;
#(
  parameter addr_t PORT_ADDR = 16'hE0C4
) (
  input  logic  bus_valid,
  input  logic  bus_rw,
  input  addr_t bus_addr,
  input  logic  degraded,
  output act_t  act
);
  logic hit;

  always_comb begin
    hit        = bus_valid && (bus_addr == PORT_ADDR);
    act.wr_hit = hit && !bus_rw;
    act.rd_hit = hit && bus_rw;
    // the inhibit lets only port writes through unless degraded
    act.smp    = degraded ? bus_valid : act.wr_hit;
  end
endmodule

// File: rtl/kmx_sampler.sv
module kmx_sampler
  import kmx_pkg::*;
#(
  parameter int ROWS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp,
  input  byte_t            sel_in,
  input  logic [ROWS*DW-1:0] row_n,
  output byte_t            store_q,
  output byte_t            sel_q
);
  byte_t masked [ROWS];
  byte_t merged;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    // a high selector bit masks the row out (reads as released)
    assign masked[r] = sel_in[r] ? '1 : row_n[r*DW +: DW];
  end

  always_comb begin
    merged = '1;
    for (int r = 0; r < ROWS; r++) merged &= masked[r];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '1;
      sel_q   <= '1;
    end else if (smp) begin
      store_q <= merged;
      sel_q   <= sel_in;
    end
  end
endmodule

// File: rtl/kmx_readback.sv
module kmx_readback
  import kmx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  rd_hit,
  input  byte_t store_q,
  output byte_t rd_data,
  output logic  rd_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '1;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_hit;
      if (rd_hit) rd_data <= store_q;  // value from before this cycle
    end
  end
endmodule

// File: rtl/kmx_latch_top.sv
module kmx_latch_top
  import kmx_pkg::*;
#(
  parameter int    ROWS      = 8,
  parameter addr_t PORT_ADDR = 16'hE0C4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_valid,
  input  logic               bus_rw,
  input  logic [15:0]        bus_addr,
  input  logic [7:0]         bus_data,
  input  logic               degraded,
  input  logic [ROWS*8-1:0]  row_n,
  output logic [7:0]         sel_lines,
  output logic [7:0]         rd_data,
  output logic               rd_valid
);
  act_t  act;
  byte_t store_q;

  kmx_decode #(.PORT_ADDR(PORT_ADDR)) dec_i (
    .bus_valid (bus_valid),
    .bus_rw    (bus_rw),
    .bus_addr  (bus_addr),
    .degraded  (degraded),
    .act       (act)
  );

  kmx_sampler #(.ROWS(ROWS)) smp_i (
    .clk     (clk),
    .rst     (rst),
    .smp     (act.smp),
    .sel_in  (bus_data),
    .row_n   (row_n),
    .store_q (store_q),
    .sel_q   (sel_lines)
  );

  kmx_readback rb_i (
    .clk      (clk),
    .rst      (rst),
    .rd_hit   (act.rd_hit),
    .store_q  (store_q),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: rtl/kmx_latch_chk.sv
module kmx_latch_chk #(
  parameter logic [15:0] PORT_ADDR = 16'hE0C4
) (
  input logic        clk,
  input logic        rst,
  input logic        bus_valid,
  input logic        bus_rw,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_data,
  input logic        degraded,
  input logic [7:0]  sel_lines,
  input logic [7:0]  rd_data,
  input logic        rd_valid
);
  logic rd_cyc, wr_cyc;
  assign rd_cyc = bus_valid && bus_rw && (bus_addr == PORT_ADDR);
  assign wr_cyc = bus_valid && !bus_rw && (bus_addr == PORT_ADDR);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (sel_lines == 8'hFF && rd_data == 8'hFF && !rd_valid));

  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_cyc |=> rd_valid);

  // R6
  rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_cyc |=> !rd_valid);

  // R3
  normal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!degraded && !wr_cyc) |=> $stable(sel_lines));

  // R2
  normal_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (!degraded && wr_cyc) |=> sel_lines == $past(bus_data));

  // R4
  degraded_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (degraded && bus_valid) |=> sel_lines == $past(bus_data));

  // R5
  degraded_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (degraded && !bus_valid) |=> $stable(sel_lines));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_cyc |=> $stable(rd_data));
endmodule

bind kmx_latch_top kmx_latch_chk #(.PORT_ADDR(PORT_ADDR)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid),
  .bus_rw    (bus_rw),
  .bus_addr  (bus_addr),
  .bus_data  (bus_data),
  .degraded  (degraded),
  .sel_lines (sel_lines),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid)
);

// File: tb/kmx_latch_tb.sv
`timescale 1ns/1ps
module kmx_latch_top_tb_top;
  localparam int          ROWS = 8;
  localparam logic [15:0] PA   = 16'hE0C4;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic              rst = 1'b1;
  logic              bus_valid = 1'b0;
  logic              bus_rw = 1'b1;
  logic [15:0]       bus_addr = 16'h0000;
  logic [7:0]        bus_data = 8'h00;
  logic              degraded = 1'b0;
  logic [ROWS*8-1:0] row_n;
  logic [7:0]        sel_lines, rd_data;
  logic              rd_valid;

  logic [7:0] keys_n [ROWS];
  always_comb for (int r = 0; r < ROWS; r++) row_n[r*8 +: 8] = keys_n[r];

  kmx_latch_top #(.ROWS(ROWS), .PORT_ADDR(PA)) dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_rw(bus_rw),
    .bus_addr(bus_addr), .bus_data(bus_data), .degraded(degraded),
    .row_n(row_n), .sel_lines(sel_lines), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int vecs = 0, errs = 0;
  string tag = "R1";
  logic [7:0] m_store = 8'hFF, m_sel = 8'hFF, m_rd = 8'hFF;
  logic       m_rv = 1'b0;

  function automatic logic [7:0] pick(input logic [7:0] s);
    logic [7:0] acc = 8'hFF;
    for (int r = 0; r < ROWS; r++) if (s[r] == 1'b0) acc = acc & keys_n[r];
    return acc;
  endfunction

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: got %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic rw, input logic [15:0] a, input logic [7:0] d);
    logic hit;
    bus_valid = v; bus_rw = rw; bus_addr = a; bus_data = d;
    @(posedge clk);
    hit = v && (a == PA);
    if (rst) begin
      m_store = 8'hFF; m_sel = 8'hFF; m_rd = 8'hFF; m_rv = 1'b0;
    end else begin
      m_rv = hit && rw;
      if (hit && rw) m_rd = m_store;
      if (degraded ? v : (hit && !rw)) begin
        m_store = pick(d);
        m_sel   = d;
      end
    end
    @(negedge clk);
    chk("sel_lines", sel_lines, m_sel);
    chk("rd_valid", {7'b0, rd_valid}, {7'b0, m_rv});
    chk("rd_data", rd_data, m_rd);
  endtask

  task automatic rd_port(input logic [7:0] d);
    step(1'b1, 1'b1, PA, d);
  endtask

  task automatic wr_port(input logic [7:0] d);
    step(1'b1, 1'b0, PA, d);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    for (int r = 0; r < ROWS; r++) keys_n[r] = 8'hFF;
    keys_n[0] = 8'hF7;  // column 3 pressed
    keys_n[2] = 8'hDE;  // columns 0 and 5
    keys_n[6] = 8'h7F;  // column 7
    @(negedge clk);
    tag = "R1";
    step(1'b1, 1'b0, PA, 8'h00);
    step(1'b1, 1'b1, PA, 8'h00);
    rst = 1'b0;
    rd_port(8'h00);  // R1: reset value reads back as FF
    chk("R1 reset readback", rd_data, 8'hFF);

    tag = "R2";
    wr_port(8'hFE); rd_port(8'h00); chk("row0", rd_data, 8'hF7);
    wr_port(8'hFB); rd_port(8'h00); chk("row2", rd_data, 8'hDE);
    wr_port(8'hBA); rd_port(8'h11); chk("rows0,2,6", rd_data, 8'h56);

    tag = "R8";
    wr_port(8'hFF); rd_port(8'h00); chk("none enabled", rd_data, 8'hFF);
    wr_port(8'h00); rd_port(8'h00); chk("all enabled", rd_data, 8'h56);

    tag = "R3";
    wr_port(8'hFE);
    keys_n[0] = 8'h00;
    step(1'b1, 1'b0, 16'h1234, 8'h00);
    step(1'b0, 1'b0, PA, 8'hFB);
    rd_port(8'hFB); rd_port(8'h00);
    chk("held after other cycles", rd_data, 8'hF7);
    keys_n[0] = 8'hF7;

    tag = "R7";
    for (int b = 0; b < 16; b++) begin
      step(1'b1, 1'b0, PA ^ (16'h1 << b), 8'hFB);
      step(1'b1, 1'b1, PA ^ (16'h1 << b), 8'hFB);
    end
    rd_port(8'h00); chk("near-miss addresses", rd_data, 8'hF7);

    tag = "R9";
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 16'h0100, 8'h00);
    chk("hold", rd_data, 8'hF7);

    tag = "R4";
    degraded = 1'b1;
    step(1'b1, 1'b1, 16'h3000, 8'hFB);   // idle-fetch style cycle
    rd_port(8'hFE);                       // R6: this cycle captures too
    chk("prior byte rules", rd_data, 8'hDE);
    step(1'b1, 1'b0, 16'h0200, 8'hBF);
    rd_port(8'h00); chk("write elsewhere", rd_data, 8'h7F);
    rd_port(8'hFF); chk("read-then-read", rd_data, 8'h56);

    tag = "R5";
    step(1'b1, 1'b1, 16'h4000, 8'hFE);
    step(1'b0, 1'b1, 16'h4001, 8'h00);
    step(1'b0, 1'b0, PA, 8'hFB);
    rd_port(8'h00); chk("invalid cycles skipped", rd_data, 8'hF7);

    tag = "R6";
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      if (i % 50 == 0) degraded = $urandom_range(0, 1);
      if (i % 37 == 0) keys_n[$urandom_range(0, ROWS-1)] = 8'($urandom);
      a = ($urandom_range(0, 2) == 0) ? 16'($urandom) : PA;
      step(1'($urandom_range(0, 3) != 0), 1'($urandom), a, 8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule